// File: doc/BRIEF.md
# Instruction Fetch Line Controller

This block brings whole instruction lines from a memory port into a single line register. It then hands out up to `LANES` sequential 32-bit instructions per cycle from that line, starting at its own program counter. Only one line request is ever in flight. A request that the memory side refuses is parked until a retry pulse arrives and is then presented again unchanged. Every response carries the ID of the request it answers. A response that does not answer the current live request is dropped and counted.

Delivery in a cycle is cut short by four things: the lane count allowed by the fetch-width input, the free slots reported by the downstream instruction buffer, a predicted-taken flag on a lane, and the end of the buffered line. When no rename registers are free, the block parks in a blocked state. A redirect loads a new program counter, abandons any outstanding access and starts a fresh line fetch.

Top module: `ifl_fetch_ctrl`

## Requirements
- R1: The request address is the program counter with its low log2(LINE_BYTES) bits cleared. Each new request carries an ID one greater than the previous one, and the first request after reset carries ID 1.
- R2: A request that is refused (request valid while accept is low) moves the block to a retry wait. In that wait no request is presented except in a cycle where the retry pulse is high, and then the same address and ID are presented. Once a request is accepted, no new request appears until its response arrives or a redirect occurs.
- R3: A response is taken only while the block is waiting for a response and the response ID equals the current request ID. Any other response is dropped, increments the drop counter and delivers nothing.
- R4: Lane k carries the program counter pc+4k. The word index of lane k is ((pc mod LINE_BYTES)>>2)+k, and the lane's instruction is bits [32*index+31 : 32*index] of the line. Its next-PC output is its PC plus 4.
- R5: The number of valid lanes in a cycle never exceeds the fetch width or the free-slot count. Valid lanes are contiguous from lane 0, and the program counter advances by 4 per delivered lane.
- R6: A lane whose predicted-taken input is high is the last valid lane of that cycle.
- R7: Lanes whose word would lie beyond the end of the line are not delivered. Once the program counter leaves the buffered line, a request for the new line follows, and nothing is delivered until its response is taken.
- R8: While the free-register count is zero, no lane is valid and the block enters a blocked state. Delivery resumes in the cycle after the cycle in which the count is non-zero.
- R9: A redirect makes every lane invalid in its own cycle and loads the redirect PC. The next cycle presents a request with a new ID for the line of that PC, and a late response to the abandoned request is dropped.
- R10: The stall counter counts cycles spent waiting for a retry or a response. The line counter counts responses taken. All three counters are 32 bits wide, start at zero and saturate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid_i | input | 1 | Redirect / squash request |
| redir_pc_i | input | ADDR_W | New program counter on redirect |
| fetch_width_i | input | FW_W | Maximum lanes this cycle |
| buf_free_i | input | BUF_W | Free slots in the downstream instruction buffer |
| free_regs_i | input | REG_W | Free rename registers |
| pred_taken_i | input | LANES | Per-lane predicted-taken flag |
| req_valid_o | output | 1 | Line request valid |
| req_addr_o | output | ADDR_W | Line-aligned request address |
| req_id_o | output | ID_W | Request ID |
| req_ready_i | input | 1 | Memory accepts the request this cycle |
| retry_i | input | 1 | Memory can now take a refused request |
| rsp_valid_i | input | 1 | Line response valid |
| rsp_id_i | input | ID_W | ID of the answered request |
| rsp_data_i | input | LINE_BYTES*8 | Line data, word i in bits [32i+31:32i] |
| out_valid_o | output | LANES | Per-lane instruction valid |
| out_inst_o | output | LANES*32 | Per-lane instruction word |
| out_pc_o | output | LANES*ADDR_W | Per-lane PC |
| out_npc_o | output | LANES*ADDR_W | Per-lane next PC |
| stall_cnt_o | output | 32 | Cycles waiting on memory |
| line_cnt_o | output | 32 | Lines received |
| drop_cnt_o | output | 32 | Responses dropped |

## Verification
Delivery is driven with full width and space, with a narrowed width, with a single free slot and with zero width. These runs separate the width limit from the buffer limit and show that a zero limit stalls without losing the PC. A predicted-taken flag on an inner lane is run against a line-end crossing that yields only two lanes, so the two kinds of early cut-off can be told apart. A double refusal followed by a retry shows that the parked request is replayed unchanged. A stale-ID response and a redirect in mid-wait, started from an unaligned PC, show that abandoned traffic is dropped and that word selection follows the PC offset.

// File: rtl/ifl_pkg.sv
package ifl_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_FETCH  = 3'd1,
    ST_WRETRY = 3'd2,
    ST_WRESP  = 3'd3,
    ST_RBLK   = 3'd4
  } ifl_state_e;
endpackage

// File: rtl/ifl_sat_cnt.sv
module ifl_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (inc && cnt != MAXV) cnt <= cnt + 1'b1;
  end

  // R10: a full counter stays full
  p_sat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAXV && inc) |=> cnt == MAXV);
endmodule

// File: rtl/ifl_lane_pick.sv
module ifl_lane_pick #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int LANES      = 4,
  parameter int FW_W       = 3,
  parameter int BUF_W      = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ena,
  input  logic [ADDR_W-1:0]       pc,
  input  logic [LINE_BYTES*8-1:0] line,
  input  logic [FW_W-1:0]         width,
  input  logic [BUF_W-1:0]        buf_free,
  input  logic [LANES-1:0]        pred,
  output logic [LANES-1:0]        valid,
  output logic [LANES*32-1:0]     inst,
  output logic [LANES*ADDR_W-1:0] lane_pc,
  output logic [LANES*ADDR_W-1:0] lane_npc,
  output logic [ADDR_W-1:0]       adv
);
  localparam int WORDS = LINE_BYTES / 4;
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = OFF_W - 2;

  logic [IDX_W-1:0] word0;
  logic [LANES-1:0] lane_ok;
  assign word0 = pc[OFF_W-1:2];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] lpc;
    assign idx = word0 + IDX_W'(k);
    assign lpc = pc + ADDR_W'(4 * k);
    assign lane_ok[k] = ena && (32'(width) > k) && (32'(buf_free) > k)
                        && ((32'(word0) + k) < WORDS);
    if (k == 0) begin : g_first
      assign valid[0] = lane_ok[0];
    end else begin : g_rest
      assign valid[k] = valid[k-1] && !pred[k-1] && lane_ok[k];
      // R6: nothing follows a predicted-taken lane
      p_pred_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid[k-1] && pred[k-1]) |-> !valid[k]);
      // R5: lanes are contiguous from lane 0
      p_contig_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid[k] |-> valid[k-1]);
    end
    assign inst[32*k +: 32]         = line[32*idx +: 32];
    assign lane_pc[ADDR_W*k +: ADDR_W]  = lpc;
    assign lane_npc[ADDR_W*k +: ADDR_W] = lpc + ADDR_W'(4);
  end

  assign adv = ADDR_W'($countones(valid)) << 2;

  // R5: lane count bounded by both limits
  p_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(valid) <= 32'(width)) && ($countones(valid) <= 32'(buf_free)));
endmodule

// File: rtl/ifl_fetch_ctrl.sv
module ifl_fetch_ctrl
  import ifl_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int LANES      = 4,
  parameter int ID_W       = 4,
  parameter int BUF_W      = 4,
  parameter int REG_W      = 8,
  parameter int FW_W       = $clog2(LANES + 1),
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    redir_valid_i,
  input  logic [ADDR_W-1:0]       redir_pc_i,
  input  logic [FW_W-1:0]         fetch_width_i,
  input  logic [BUF_W-1:0]        buf_free_i,
  input  logic [REG_W-1:0]        free_regs_i,
  input  logic [LANES-1:0]        pred_taken_i,
  output logic                    req_valid_o,
  output logic [ADDR_W-1:0]       req_addr_o,
  output logic [ID_W-1:0]         req_id_o,
  input  logic                    req_ready_i,
  input  logic                    retry_i,
  input  logic                    rsp_valid_i,
  input  logic [ID_W-1:0]         rsp_id_i,
  input  logic [LINE_BYTES*8-1:0] rsp_data_i,
  output logic [LANES-1:0]        out_valid_o,
  output logic [LANES*32-1:0]     out_inst_o,
  output logic [LANES*ADDR_W-1:0] out_pc_o,
  output logic [LANES*ADDR_W-1:0] out_npc_o,
  output logic [31:0]             stall_cnt_o,
  output logic [31:0]             line_cnt_o,
  output logic [31:0]             drop_cnt_o
);
  localparam int LINE_BITS = LINE_BYTES * 8;
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(LINE_BYTES - 1);

  function automatic logic [ADDR_W-1:0] line_base(input logic [ADDR_W-1:0] a);
    return a & ~OFF_MASK;
  endfunction

  ifl_state_e            st;
  logic [ADDR_W-1:0]     pc, base;
  logic [ID_W-1:0]       cur_id;
  logic                  line_vld;
  logic [LINE_BITS-1:0]  line_q;
  logic [ADDR_W-1:0]     adv;

  // named internal events
  logic in_line, ev_accept, ev_drop, ev_refuse, ev_stall, deliver_en;
  assign in_line    = line_vld && (line_base(pc) == base);
  assign ev_accept  = rsp_valid_i && st == ST_WRESP && rsp_id_i == cur_id && !redir_valid_i;
  assign ev_drop    = rsp_valid_i && !ev_accept;
  assign ev_refuse  = req_valid_o && !req_ready_i;
  assign ev_stall   = (st == ST_WRETRY) || (st == ST_WRESP);
  assign deliver_en = st == ST_RUN && in_line && free_regs_i != '0 && !redir_valid_i;

  assign req_valid_o = (st == ST_FETCH) || (st == ST_WRETRY && retry_i);
  assign req_addr_o  = line_base(pc);
  assign req_id_o    = cur_id;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_RUN;
      pc       <= RESET_PC;
      base     <= '0;
      cur_id   <= '0;
      line_vld <= 1'b0;
      line_q   <= '0;
    end else if (redir_valid_i) begin
      pc       <= redir_pc_i;
      line_vld <= 1'b0;
      cur_id   <= cur_id + 1'b1;
      st       <= ST_FETCH;
    end else begin
      unique case (st)
        ST_RUN: begin
          if (!in_line) begin
            cur_id <= cur_id + 1'b1;
            st     <= ST_FETCH;
          end else if (free_regs_i == '0) begin
            st <= ST_RBLK;
          end else begin
            pc <= pc + adv;
          end
        end
        ST_FETCH: begin
          base <= line_base(pc);
          st   <= req_ready_i ? ST_WRESP : ST_WRETRY;
        end
        ST_WRETRY: if (retry_i && req_ready_i) st <= ST_WRESP;
        ST_WRESP: if (ev_accept) begin
          line_q   <= rsp_data_i;
          line_vld <= 1'b1;
          st       <= ST_RUN;
        end
        ST_RBLK: if (free_regs_i != '0) st <= ST_RUN;
        default: st <= ST_RUN;
      endcase
    end
  end

  ifl_lane_pick #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .LANES(LANES),
    .FW_W(FW_W), .BUF_W(BUF_W)
  ) u_pick (
    .clk(clk), .rst_n(rst_n), .ena(deliver_en), .pc(pc), .line(line_q),
    .width(fetch_width_i), .buf_free(buf_free_i), .pred(pred_taken_i),
    .valid(out_valid_o), .inst(out_inst_o), .lane_pc(out_pc_o),
    .lane_npc(out_npc_o), .adv(adv)
  );

  ifl_sat_cnt #(.W(32)) u_stall (.clk(clk), .rst_n(rst_n), .inc(ev_stall),  .cnt(stall_cnt_o));
  ifl_sat_cnt #(.W(32)) u_lines (.clk(clk), .rst_n(rst_n), .inc(ev_accept), .cnt(line_cnt_o));
  ifl_sat_cnt #(.W(32)) u_drops (.clk(clk), .rst_n(rst_n), .inc(ev_drop),   .cnt(drop_cnt_o));

  // R2: refused request is replayed unchanged
  p_refuse_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_refuse && !redir_valid_i) |=> ($stable(req_addr_o) && $stable(req_id_o)));
  // R2: single outstanding request
  p_single_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_ready_i && !redir_valid_i) |=> !req_valid_o);
  // R3: every dropped response is counted
  p_drop_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_drop && drop_cnt_o != '1) |=> drop_cnt_o == $past(drop_cnt_o) + 32'd1);
  // R7: nothing delivered outside the run state
  p_no_deliver_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_RUN) |-> out_valid_o == '0);
  // R8: no delivery without free registers
  p_no_regs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (free_regs_i == '0) |-> out_valid_o == '0);
  // R9: redirect starts a fresh fetch
  p_redir_r9: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid_i |=> (st == ST_FETCH && !line_vld && out_valid_o == '0));
endmodule

// File: tb/ifl_fetch_ctrl_bench.sv
module ifl_fetch_ctrl_bench;
  localparam int ADDR_W = 32, LINE_BYTES = 32, LANES = 4, ID_W = 4;
  localparam int BUF_W = 4, REG_W = 8, FW_W = 3, LB = LINE_BYTES * 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic redir_valid_i = 0; logic [ADDR_W-1:0] redir_pc_i = 0;
  logic [FW_W-1:0] fetch_width_i = 4; logic [BUF_W-1:0] buf_free_i = 4;
  logic [REG_W-1:0] free_regs_i = 8; logic [LANES-1:0] pred_taken_i = 0;
  logic req_valid_o; logic [ADDR_W-1:0] req_addr_o; logic [ID_W-1:0] req_id_o;
  logic req_ready_i = 1, retry_i = 0, rsp_valid_i = 0;
  logic [ID_W-1:0] rsp_id_i = 0; logic [LB-1:0] rsp_data_i = 0;
  logic [LANES-1:0] out_valid_o; logic [LANES*32-1:0] out_inst_o;
  logic [LANES*ADDR_W-1:0] out_pc_o, out_npc_o;
  logic [31:0] stall_cnt_o, line_cnt_o, drop_cnt_o;
  int n_chk = 0, n_bad = 0;
  logic [31:0] s0, d0;

  always #4 clk = ~clk;

  ifl_fetch_ctrl u_ifl_fetch_ctrl (.*);

  function automatic logic [31:0] wrd(input logic [31:0] a);
    return {16'hC0DE, a[15:0] & 16'hFFFC};
  endfunction
  function automatic logic [LB-1:0] mkline(input logic [31:0] b);
    logic [LB-1:0] l;
    for (int i = 0; i < LINE_BYTES / 4; i++) l[32*i +: 32] = wrd(b + 32'(4 * i));
    return l;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_lanes(input string tag, input logic [LANES-1:0] ev, input logic [31:0] p0);
    chk({tag, " valid"}, 64'(out_valid_o), 64'(ev));
    for (int k = 0; k < LANES; k++) if (ev[k]) begin
      chk({tag, " R4 pc"},   64'(out_pc_o[ADDR_W*k +: ADDR_W]),  64'(p0 + 32'(4*k)));
      chk({tag, " R4 npc"},  64'(out_npc_o[ADDR_W*k +: ADDR_W]), 64'(p0 + 32'(4*k + 4)));
      chk({tag, " R4 inst"}, 64'(out_inst_o[32*k +: 32]),        64'(wrd(p0 + 32'(4*k))));
    end
  endtask

  task automatic poll_req(input string tag, input logic [31:0] a, input logic [ID_W-1:0] id);
    #1;
    for (int i = 0; i < 20; i++) begin
      if (req_valid_o) break;
      @(negedge clk); #1;
    end
    chk({tag, " req valid"}, 64'(req_valid_o), 64'd1);
    chk({tag, " R1 addr"},   64'(req_addr_o), 64'(a));
    chk({tag, " R1 id"},     64'(req_id_o),   64'(id));
  endtask

  task automatic serve(input string tag, input logic [31:0] a, input logic [ID_W-1:0] id);
    poll_req(tag, a, id);
    @(negedge clk);
    rsp_valid_i = 1; rsp_id_i = id; rsp_data_i = mkline(a);
    @(negedge clk);
    rsp_valid_i = 0;
  endtask

  task automatic step(input string tag, input logic [FW_W-1:0] w, input logic [BUF_W-1:0] b,
                      input logic [LANES-1:0] pr, input logic [LANES-1:0] ev, input logic [31:0] p0);
    fetch_width_i = w; buf_free_i = b; pred_taken_i = pr;
    #1;
    chk_lanes(tag, ev, p0);
    @(negedge clk);
    fetch_width_i = 4; buf_free_i = 4; pred_taken_i = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    #1;
    chk("R10 stall reset", 64'(stall_cnt_o), 0);
    chk("R10 line reset",  64'(line_cnt_o), 0);
    chk("R10 drop reset",  64'(drop_cnt_o), 0);
    chk("R7 no lanes in reset", 64'(out_valid_o), 0);
    rst_n = 1;
  endtask

  task automatic t_basic();
    serve("R1 first", 0, 1);
    step("R5 full", 4, 4, 0, 4'b1111, 0);
    step("R5 second half", 4, 4, 0, 4'b1111, 16);
    #1 chk("R10 line count", 64'(line_cnt_o), 1);
  endtask

  task automatic t_width();
    serve("R7 next line", 32, 2);
    step("R5 width 3", 3, 4, 0, 4'b0111, 32);
    step("R5 one slot", 4, 1, 0, 4'b0001, 44);
    step("R5 width 0", 0, 4, 0, 4'b0000, 48);
    step("R5 resume", 4, 4, 0, 4'b1111, 48);
  endtask

  task automatic t_pred();
    serve("R1 line 64", 64, 3);
    step("R6 taken lane1", 4, 4, 4'b0010, 4'b0011, 64);
    step("R6 after taken", 4, 4, 0, 4'b1111, 72);
    step("R7 line end", 4, 4, 0, 4'b0011, 88);
  endtask

  task automatic t_rename();
    serve("R7 line 96", 96, 4);
    free_regs_i = 0;
    step("R8 zero regs", 4, 4, 0, 4'b0000, 96);
    step("R8 blocked", 4, 4, 0, 4'b0000, 96);
    free_regs_i = 5;
    step("R8 leaving", 4, 4, 0, 4'b0000, 96);
    step("R8 resumed", 4, 4, 0, 4'b1111, 96);
    step("R8 rest", 4, 4, 0, 4'b1111, 112);
  endtask

  task automatic t_retry();
    req_ready_i = 0;
    poll_req("R2 refused", 128, 5);
    @(negedge clk); #1;
    chk("R2 quiet in retry wait", 64'(req_valid_o), 0);
    s0 = stall_cnt_o;
    @(negedge clk); #1;
    chk("R2 still quiet", 64'(req_valid_o), 0);
    chk("R10 stall counts", 64'(stall_cnt_o), 64'(s0 + 1));
    retry_i = 1; #1;
    chk("R2 replay valid", 64'(req_valid_o), 1);
    chk("R2 replay addr",  64'(req_addr_o), 128);
    chk("R2 replay id",    64'(req_id_o), 5);
    @(negedge clk); retry_i = 0; #1;
    chk("R2 quiet after refusal", 64'(req_valid_o), 0);
    retry_i = 1; req_ready_i = 1; #1;
    chk("R2 second replay id", 64'(req_id_o), 5);
    @(negedge clk); retry_i = 0; #1;
    chk("R2 single outstanding", 64'(req_valid_o), 0);
    rsp_valid_i = 1; rsp_id_i = 3; rsp_data_i = '1;
    @(negedge clk);
    rsp_id_i = 5; rsp_data_i = mkline(128); #1;
    chk("R3 wrong id dropped", 64'(drop_cnt_o), 1);
    chk("R3 nothing delivered", 64'(out_valid_o), 0);
    @(negedge clk); rsp_valid_i = 0;
    step("R3 match taken", 4, 4, 0, 4'b1111, 128);
    step("R3 rest", 4, 4, 0, 4'b1111, 144);
  endtask

  task automatic t_redir();
    poll_req("R1 line 160", 160, 6);
    @(negedge clk);
    redir_valid_i = 1; redir_pc_i = 32'h206; #1;
    chk("R9 no lanes on redirect", 64'(out_valid_o), 0);
    @(negedge clk); redir_valid_i = 0;
    poll_req("R9 new request", 32'h200, 7);
    @(negedge clk);
    rsp_valid_i = 1; rsp_id_i = 6; rsp_data_i = mkline(160);
    d0 = drop_cnt_o;
    @(negedge clk);
    rsp_id_i = 7; rsp_data_i = mkline(32'h200); #1;
    chk("R9 stale dropped", 64'(drop_cnt_o), 64'(d0 + 1));
    @(negedge clk); rsp_valid_i = 0;
    step("R4 unaligned pc", 4, 4, 0, 4'b1111, 32'h206);
    #1 chk("R10 lines taken", 64'(line_cnt_o), 6);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_width();
    t_pred();
    t_rename();
    t_retry();
    t_redir();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule